// File: doc/BRIEF.md
# Multi-Master Hardware Semaphore Bank

This block holds a bank of hardware semaphores that lets several processors on one chip coordinate through a simple register bus. Each bus access carries a 4-bit master identifier as a sideband signal. To take a semaphore, a master writes a nonzero value to that semaphore's word. It then reads the word back. It holds the semaphore only if its own identifier comes back in the low four bits. To free the semaphore, the owner writes zero to the word.

The bank also has a control word with a protocol-select bit and a 16-bit release-event field. Every accepted release sets a bit in the release-event field, and software clears the bits by writing ones to them. The bus has no back-pressure. A request is accepted in the cycle `bus_req` is high. A read returns its data on `rsp_rdata`, with `rsp_valid` high, exactly one cycle later. A write never produces a response. Only one access can occur per cycle.

Top module: `hsem_bank`

## Requirements
- R1: After reset every semaphore word reads 0 (free), the control word at 0x00 reads 0, and the release-event field at 0x90 reads 0.
- R2: Semaphore i (0..31) sits at byte offset 0x08 + 4*i. A nonzero write to a free semaphore by a master with a nonzero identifier stores that master's identifier. A read returns the owner in bits [3:0] and zero in bits [31:4].
- R3: A nonzero write to a semaphore that is already held leaves the owner unchanged. This applies to every master, including the current owner.
- R4: A write of zero by the master whose identifier equals the current owner frees the semaphore.
- R5: A zero write from any other master has no effect, and neither does a zero write to a free semaphore. Neither case records a release event.
- R6: Each accepted release sets bit (i mod 16) of the release-event field. The field is read at 0x90 in bits [15:0].
- R7: A write to 0x90 clears every release-event bit whose write-data bit is 1. Writing 0xFFFF clears them all.
- R8: Bit 0 of the control word at 0x00 is readable and writable. All other bits of that word read zero.
- R9: A read request is answered one cycle later with `rsp_valid` high and the registered data. `rsp_valid` is low in every other cycle, including the cycle after a write.
- R10: Reads of unmapped offsets return zero, and writes to them change no state. Offsets with nonzero bits [1:0] count as unmapped.
- R11: A nonzero write from master identifier 0 does not claim a free semaphore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, accepted in the same cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_mid | input | 4 | Identifier of the requesting master |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Registered read data |

## Verification
The embedded assertions check the ownership rules on every cycle: a claim of a free slot stores the requester, a held slot ignores further claims, and a slot never changes without a write to it. They also check that the response strobe tracks read requests one cycle later, that unmapped reads return zero, and that the event field moves only on a release or a clear. Only the bench scenarios can show the address map itself, the end-to-end effect of a claim-then-read-back from contending masters, and the mapping of releases to event bits modulo 16 (for example, semaphore 31 landing on bit 15). The same holds for partial write-one-to-clear masks and for misaligned addresses having no effect.

// File: rtl/hsem_pkg.sv
package hsem_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int MID_W    = 4;
  localparam int NUM_SEM  = 32;
  localparam int EVT_W    = 16;
  localparam int CTRL_OFS = 'h00;
  localparam int SEM_OFS  = 'h08;
  localparam int EVT_OFS  = 'h90;
  localparam int IDX_W    = $clog2(NUM_SEM);

  typedef struct packed {
    logic             hit_ctrl;
    logic             hit_evt;
    logic             hit_sem;
    logic [IDX_W-1:0] sem_idx;
  } dec_t;
endpackage

// File: rtl/hsem_decode.sv
module hsem_decode
  import hsem_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam int SEM_END = SEM_OFS + 4*NUM_SEM;
  logic aligned;

  always_comb begin
    aligned      = (addr[1:0] == 2'b00);
    dec.hit_ctrl = (int'(addr) == CTRL_OFS);
    dec.hit_evt  = (int'(addr) == EVT_OFS);
    dec.hit_sem  = aligned && (int'(addr) >= SEM_OFS) && (int'(addr) < SEM_END);
    dec.sem_idx  = IDX_W'((addr - ADDR_W'(SEM_OFS)) >> 2);
  end
endmodule

// File: rtl/hsem_slot.sv
module hsem_slot
  import hsem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_zero,
  input  logic [MID_W-1:0] wr_mid,
  output logic [MID_W-1:0] owner,
  output logic             rel_pulse
);
  logic claim;

  always_comb begin
    claim     = wr_en && !wr_zero && (owner == '0) && (wr_mid != '0);
    rel_pulse = wr_en && wr_zero && (owner != '0) && (wr_mid == owner);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         owner <= '0;
    else if (claim)     owner <= wr_mid;
    else if (rel_pulse) owner <= '0;
  end

  // R2
  claim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_zero && owner == '0 && wr_mid != '0) |=> (owner == $past(wr_mid)));

  // R3
  held_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_zero && owner != '0) |=> $stable(owner));

  // R11
  mid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mid == '0) |=> $stable(owner));

  // R5
  no_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> $stable(owner));
endmodule

// File: rtl/hsem_evt.sv
module hsem_evt
  import hsem_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SEM-1:0] rel_vec,
  input  logic               clr_en,
  input  logic [EVT_W-1:0]   clr_mask,
  output logic [EVT_W-1:0]   pend
);
  logic [EVT_W-1:0] set_vec;

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < NUM_SEM; i++)
      if (rel_vec[i]) set_vec[i % EVT_W] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      pend <= '0;
    else if (clr_en) pend <= pend & ~clr_mask;
    else             pend <= pend | set_vec;
  end

  // R6
  evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en && rel_vec == '0) |=> $stable(pend));

  // R7
  evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((pend & $past(clr_mask)) == '0));
endmodule

// File: rtl/hsem_bank.sv
module hsem_bank
  import hsem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [MID_W-1:0]  bus_mid,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  dec_t                         dec;
  logic [NUM_SEM-1:0][MID_W-1:0] owners;
  logic [NUM_SEM-1:0]           rel_vec;
  logic [EVT_W-1:0]             pend;
  logic                         ctrl_q;
  logic                         wr_any, rd_any, hit_any;
  logic [DATA_W-1:0]            rd_next;

  hsem_decode u_dec (.addr(bus_addr), .dec(dec));

  assign wr_any  = bus_req && bus_we;
  assign rd_any  = bus_req && !bus_we;
  assign hit_any = dec.hit_ctrl || dec.hit_evt || dec.hit_sem;

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_slot
    hsem_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_any && dec.hit_sem && (dec.sem_idx == IDX_W'(g))),
      .wr_zero  (bus_wdata == '0),
      .wr_mid   (bus_mid),
      .owner    (owners[g]),
      .rel_pulse(rel_vec[g])
    );
  end

  hsem_evt u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .rel_vec (rel_vec),
    .clr_en  (wr_any && dec.hit_evt),
    .clr_mask(bus_wdata[EVT_W-1:0]),
    .pend    (pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                       ctrl_q <= 1'b0;
    else if (wr_any && dec.hit_ctrl)  ctrl_q <= bus_wdata[0];
  end

  always_comb begin
    rd_next = '0;
    if (dec.hit_ctrl)     rd_next = DATA_W'(ctrl_q);
    else if (dec.hit_evt) rd_next = DATA_W'(pend);
    else if (dec.hit_sem) rd_next = DATA_W'(owners[dec.sem_idx]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_any;
      rsp_rdata <= rd_any ? rd_next : '0;
    end
  end

  // R9
  rsp_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> rsp_valid);

  // R9
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |=> !rsp_valid);

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && !hit_any) |=> (rsp_rdata == '0));

  // R8
  ctrl_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && dec.hit_ctrl) |=> (rsp_rdata[DATA_W-1:1] == '0));
endmodule

// File: tb/hsem_bank_tb.sv
module hsem_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_mid = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsem_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_mid(bus_mid),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] m);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_mid = m;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    check("R9 no response after write", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_mid = 4'h1;
    @(negedge clk);
    bus_req = 1'b0;
    check("R9 response valid", {31'b0, rsp_valid}, 32'd1);
    d = rsp_rdata;
  endtask

  function automatic logic [7:0] sem_a(input int i);
    return 8'(8 + 4*i);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    for (int i = 0; i < 32; i++) begin
      bus_read(sem_a(i), d);
      check("R1 semaphore free", d, 0);
    end
    bus_read(8'h00, d); check("R1 control zero", d, 0);
    bus_read(8'h90, d); check("R1 events zero", d, 0);
  endtask

  task automatic t_claim();
    logic [31:0] d;
    bus_write(sem_a(0), 32'h3, 4'h3);
    bus_read(sem_a(0), d); check("R2 claim sem0", d, 32'h3);
    bus_write(sem_a(31), 32'hFFFF_FFFF, 4'hF);
    bus_read(sem_a(31), d); check("R2 claim sem31 upper zero", d, 32'hF);
    bus_read(sem_a(1), d); check("R2 neighbour untouched", d, 0);
  endtask

  task automatic t_contend();
    logic [31:0] d;
    bus_write(sem_a(0), 32'h5, 4'h5);
    bus_read(sem_a(0), d); check("R3 other master rejected", d, 32'h3);
    bus_write(sem_a(0), 32'h3, 4'h3);
    bus_read(sem_a(0), d); check("R3 owner rewrite keeps", d, 32'h3);
  endtask

  task automatic t_release();
    logic [31:0] d;
    bus_write(sem_a(0), 32'h0, 4'h5);
    bus_read(sem_a(0), d); check("R5 foreign release ignored", d, 32'h3);
    bus_read(8'h90, d); check("R5 no event on ignored release", d, 0);
    bus_write(sem_a(4), 32'h0, 4'h0);
    bus_read(8'h90, d); check("R5 no event on free release", d, 0);
    bus_write(sem_a(0), 32'h0, 4'h3);
    bus_read(sem_a(0), d); check("R4 owner release", d, 0);
    bus_read(8'h90, d); check("R6 event bit0", d, 32'h1);
    bus_write(sem_a(31), 32'h0, 4'hF);
    bus_read(8'h90, d); check("R6 sem31 maps to bit15", d, 32'h8001);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    bus_write(8'h90, 32'h0001, 4'h1);
    bus_read(8'h90, d); check("R7 partial clear", d, 32'h8000);
    bus_write(sem_a(17), 32'h2, 4'h2);
    bus_write(sem_a(17), 32'h0, 4'h2);
    bus_read(8'h90, d); check("R6 sem17 maps to bit1", d, 32'h8002);
    bus_write(8'h90, 32'hFFFF, 4'h1);
    bus_read(8'h90, d); check("R7 clear all", d, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    bus_write(8'h00, 32'hFFFF_FFFF, 4'h1);
    bus_read(8'h00, d); check("R8 control bit0 set", d, 32'h1);
    bus_write(8'h00, 32'h0, 4'h1);
    bus_read(8'h00, d); check("R8 control cleared", d, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_write(8'h04, 32'hFFFF_FFFF, 4'h4);
    bus_write(8'h88, 32'hFFFF_FFFF, 4'h4);
    bus_write(8'h09, 32'h4, 4'h4);
    bus_read(8'h04, d); check("R10 read 0x04 zero", d, 0);
    bus_read(8'h88, d); check("R10 read 0x88 zero", d, 0);
    bus_read(8'hF0, d); check("R10 read 0xF0 zero", d, 0);
    bus_read(sem_a(0), d); check("R10 misaligned write ignored", d, 0);
    bus_read(sem_a(1), d); check("R10 misaligned neighbour", d, 0);
    bus_read(8'h00, d); check("R10 control untouched", d, 0);
  endtask

  task automatic t_mid_zero();
    logic [31:0] d;
    bus_write(sem_a(2), 32'h7, 4'h0);
    bus_read(sem_a(2), d); check("R11 master 0 cannot claim", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R9 idle after reset", {31'b0, rsp_valid}, 32'd0);
    t_reset();
    t_claim();
    t_contend();
    t_release();
    t_clear();
    t_ctrl();
    t_unmapped();
    t_mid_zero();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule